// File: doc/BRIEF.md
# Periodic / One-Shot Comparator Timer Channel

This block is a single channel of a timer. Each cycle it compares a free-running 32-bit main counter, supplied from outside together with its enable, against its own comparator value and raises a one-cycle match strobe when the two meet. The channel can run in one-shot mode, where the comparator stays put and the next match only comes after the counter wraps around, or in periodic mode, where every match moves the comparator forward by a stored period. Interrupt delivery is left to a separate status block that consumes the match strobe.

The channel holds a control word. Some bits are writable: interrupt enable, periodic type, value-set, level type and message enable. Other bits are fixed capabilities: periodic-capable, 64-bit-size, message-capable, and a route mask in the upper half. The channel also holds a comparator and a period. A register interface writes the control word or the comparator using a data word and a bit mask, and reads all three back. A control state machine with three states, ST_IDLE, ST_ARMED and ST_CATCHUP, decides when matches count and when a periodic channel must catch up after the counter has run past its comparator. The transitions are:

- ST_IDLE to ST_ARMED when the channel is running and no catch-up is needed.
- ST_IDLE to ST_CATCHUP when the channel is running and the counter has overrun a periodic comparator.
- ST_ARMED to ST_IDLE when the channel stops running or its periodic type toggles.
- ST_CATCHUP to ST_ARMED when the remaining overrun drops below one period.
- ST_CATCHUP to ST_IDLE when the channel stops running, its periodic type toggles, or a comparator write arrives.

Top module: `tmr_chan`

## Requirements
- R1: After reset the comparator reads all ones, the period reads zero, match_o is low, and the control word reads the route mask in bits 63:32, message-capable (bit 10) as set by parameter, 64-bit-size (bit 9) as 0, periodic-capable (bit 8) as 1, and all writable bits as 0.
- R2: Only bits 4:0 of the control word are writable under wr_mask_i: interrupt enable (bit 0), periodic type (bit 1), value-set (bit 2), level type (bit 3) and message enable (bit 4). The 32-bit-mode bit (bit 5) always reads 0, and the capability bits never change.
- R3: The channel is active when interrupt enable or periodic type is set. An inactive channel never raises match_o.
- R4: match_o is high for exactly the cycle after a cycle in which cnt_en_i is 1, the channel is active, it is not catching up, and cnt_val_i equals the comparator. It is never raised for a cycle with cnt_en_i at 0.
- R5: In periodic mode a comparator write always merges the masked data into the period. It also loads the merged value into the comparator only when value-set is 1.
- R6: Value-set reads 0 after any comparator write.
- R7: In one-shot mode a comparator write merges the masked data into the comparator and sets the period to zero.
- R8: A control write that clears periodic type sets the period to zero, and the period is always zero while periodic type is 0.
- R9: On a match in periodic mode the comparator advances by the period. In one-shot mode it is unchanged, so the next match needs a full 32-bit counter wrap.
- R10: When a periodic channel with a nonzero period starts running while the counter is ahead of the comparator by delta (1 to 2^31-1 ticks), the comparator becomes old + (delta / period + 1) × period, taking delta / period + 1 cycles, with no match raised meanwhile.
- R11: A control write that leaves the control word unchanged has no effect on the state machine or the comparator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Main counter enable |
| cnt_val_i | input | CNT_W | Current main counter value |
| cfg_wr_i | input | 1 | Write strobe for the control word |
| cmp_wr_i | input | 1 | Write strobe for the comparator |
| wr_data_i | input | 32 | Write data |
| wr_mask_i | input | 32 | Per-bit write mask |
| cfg_rd_o | output | 64 | Control word read-back |
| cmp_rd_o | output | CNT_W | Comparator read-back |
| period_rd_o | output | CNT_W | Period read-back |
| match_o | output | 1 | One-cycle match strobe |

## Verification
A table of register writes, applied with the counter stopped, drives the comparator-write steering through every combination of mode and value-set. It also sends partial masks and writes aimed at read-only bits. This separates the period path from the comparator path. Counter sweeps then run the channel in four ways, and each count of match pulses tells a different fault apart:
- inactive, to show the active rule;
- one-shot, to show a single match and then a match only after a wrap;
- periodic-only, to show the period advance;
- enabled but stopped, to show the enable gate.

Held counter values ahead of the comparator exercise catch-up with a remainder and with an exact multiple. An unchanged control write made while armed and overrun shows that a no-op write does not start catch-up.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CATCHUP = 2'd2
    } chan_state_e;

    localparam int CTL_W  = 5;
    localparam int B_IEN  = 0;
    localparam int B_PER  = 1;
    localparam int B_VSET = 2;
    localparam int B_LVL  = 3;
    localparam int B_MSGE = 4;
    localparam int B_M32  = 5;
    localparam int B_PCAP = 8;
    localparam int B_SZ64 = 9;
    localparam int B_MCAP = 10;

endpackage

// File: rtl/chan_cfg_reg.sv
module chan_cfg_reg
    import tmr_chan_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAPS = 32'h00F0_0000,
    parameter bit          MSG_CAP    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cmp_wr,
    input  logic [CTL_W-1:0] wr_data,
    input  logic [CTL_W-1:0] wr_mask,
    output logic             ien,
    output logic             per,
    output logic             vset,
    output logic             per_toggle,
    output logic             per_clear,
    output logic [63:0]      cfg_word
);

    logic [CTL_W-1:0] ctl_q, ctl_nx, ctl_d;
    logic             changed;

    always_comb begin
        ctl_nx     = (ctl_q & ~wr_mask) | (wr_data & wr_mask);
        changed    = cfg_wr && (ctl_nx != ctl_q);
        per_toggle = changed && (ctl_nx[B_PER] != ctl_q[B_PER]);
        per_clear  = per_toggle && !ctl_nx[B_PER];
        ctl_d      = changed ? ctl_nx : ctl_q;
        if (cmp_wr) ctl_d[B_VSET] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ien  = ctl_q[B_IEN];
    assign per  = ctl_q[B_PER];
    assign vset = ctl_q[B_VSET];

    always_comb begin
        cfg_word             = '0;
        cfg_word[CTL_W-1:0]  = ctl_q;
        cfg_word[B_M32]      = 1'b0;
        cfg_word[B_PCAP]     = 1'b1;
        cfg_word[B_SZ64]     = 1'b0;
        cfg_word[B_MCAP]     = MSG_CAP;
        cfg_word[63:32]      = ROUTE_CAPS;
    end

    AST_VSET_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr |=> !vset); // R6

endmodule

// File: rtl/chan_cmp_regs.sv
module chan_cmp_regs #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] wr_mask,
    input  logic             per,
    input  logic             vset,
    input  logic             per_clear,
    input  logic             match_hit,
    input  logic             catch_step,
    output logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] period_q
);

    logic [CNT_W-1:0] merged_per, merged_cmp, cmp_d, period_d;

    always_comb begin
        merged_per = (period_q & ~wr_mask) | (wr_data & wr_mask);
        merged_cmp = (cmp_q & ~wr_mask) | (wr_data & wr_mask);
        cmp_d      = cmp_q;
        period_d   = period_q;
        if (catch_step || (match_hit && per))
            cmp_d = cmp_q + period_q;
        if (cmp_wr) begin
            if (per) begin
                period_d = merged_per;
                if (vset) cmp_d = merged_per;
            end else begin
                period_d = '0;
                cmp_d    = merged_cmp;
            end
        end
        if (per_clear) period_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q    <= '1;
            period_q <= '0;
        end else begin
            cmp_q    <= cmp_d;
            period_q <= period_d;
        end
    end

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr && !per && !catch_step) |=> $stable(cmp_q)); // R9

endmodule

// File: rtl/chan_ctrl_fsm.sv
module chan_ctrl_fsm
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] period,
    input  logic             active,
    input  logic             per,
    input  logic             per_toggle,
    input  logic             cmp_wr,
    output logic             match_hit,
    output logic             catch_step,
    output logic             match_q
);

    chan_state_e      state_q, state_d;
    logic [CNT_W-1:0] overrun, rem_q;
    logic             running, stop_arm, stop_catch, need_catch;

    always_comb begin
        overrun    = cnt_val - cmp;
        running    = active && cnt_en;
        stop_arm   = !running || per_toggle;
        stop_catch = stop_arm || cmp_wr;
        need_catch = per && (period != '0) && (overrun != '0) && !overrun[CNT_W-1];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (!stop_catch) state_d = need_catch ? ST_CATCHUP : ST_ARMED;
            ST_ARMED:   if (stop_arm) state_d = ST_IDLE;
            ST_CATCHUP: begin
                if (stop_catch)          state_d = ST_IDLE;
                else if (rem_q < period) state_d = ST_ARMED;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign catch_step = (state_q == ST_CATCHUP) && !stop_catch;
    assign match_hit  = running && (state_q != ST_CATCHUP) && (cnt_val == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= match_hit;
            if (state_q == ST_IDLE && state_d == ST_CATCHUP)
                rem_q <= overrun;
            else if (catch_step && rem_q >= period)
                rem_q <= rem_q - period;
        end
    end

    AST_CATCHUP_PERIODIC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CATCHUP) |-> (per && period != '0)); // R10
    AST_NO_MATCH_IN_CATCHUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CATCHUP) |=> !match_q); // R10

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter logic [31:0] ROUTE_CAPS = 32'h00F0_0000,
    parameter bit          MSG_CAP    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    input  logic             cfg_wr_i,
    input  logic             cmp_wr_i,
    input  logic [31:0]      wr_data_i,
    input  logic [31:0]      wr_mask_i,
    output logic [63:0]      cfg_rd_o,
    output logic [CNT_W-1:0] cmp_rd_o,
    output logic [CNT_W-1:0] period_rd_o,
    output logic             match_o
);

    logic ien, per, vset, per_toggle, per_clear, active;
    logic match_hit, catch_step;

    assign active = ien || per;

    chan_cfg_reg #(.ROUTE_CAPS(ROUTE_CAPS), .MSG_CAP(MSG_CAP)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr_i),
        .cmp_wr     (cmp_wr_i),
        .wr_data    (wr_data_i[CTL_W-1:0]),
        .wr_mask    (wr_mask_i[CTL_W-1:0]),
        .ien        (ien),
        .per        (per),
        .vset       (vset),
        .per_toggle (per_toggle),
        .per_clear  (per_clear),
        .cfg_word   (cfg_rd_o)
    );

    chan_cmp_regs #(.CNT_W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_wr     (cmp_wr_i),
        .wr_data    (wr_data_i[CNT_W-1:0]),
        .wr_mask    (wr_mask_i[CNT_W-1:0]),
        .per        (per),
        .vset       (vset),
        .per_clear  (per_clear),
        .match_hit  (match_hit),
        .catch_step (catch_step),
        .cmp_q      (cmp_rd_o),
        .period_q   (period_rd_o)
    );

    chan_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en_i),
        .cnt_val    (cnt_val_i),
        .cmp        (cmp_rd_o),
        .period     (period_rd_o),
        .active     (active),
        .per        (per),
        .per_toggle (per_toggle),
        .cmp_wr     (cmp_wr_i),
        .match_hit  (match_hit),
        .catch_step (catch_step),
        .match_q    (match_o)
    );

    AST_MATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(cnt_en_i) && $past(active))); // R4
    AST_PERIOD_ZERO_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !per |-> (period_rd_o == '0)); // R8
    AST_CAPS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_rd_o[63:CTL_W])); // R2

endmodule

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en_i = 1'b0;
    logic [31:0] cnt_val_i = '0;
    logic        cfg_wr_i = 1'b0;
    logic        cmp_wr_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] wr_mask_i = '0;
    logic [63:0] cfg_rd_o;
    logic [31:0] cmp_rd_o;
    logic [31:0] period_rd_o;
    logic        match_o;

    int checks = 0;
    int failures = 0;
    int nmatch;
    logic [31:0] last_match;

    always #4 clk = ~clk;

    tmr_chan dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en_i), .cnt_val_i(cnt_val_i),
        .cfg_wr_i(cfg_wr_i), .cmp_wr_i(cmp_wr_i), .wr_data_i(wr_data_i),
        .wr_mask_i(wr_mask_i), .cfg_rd_o(cfg_rd_o), .cmp_rd_o(cmp_rd_o),
        .period_rd_o(period_rd_o), .match_o(match_o)
    );

    typedef struct packed {
        logic        is_cmp;
        logic [31:0] data;
        logic [31:0] mask;
        logic [31:0] exp_cfg;
        logic [31:0] exp_cmp;
        logic [31:0] exp_per;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, 32'h0000_0100, 32'hFFFF_FFFF, 32'h500, 32'h100, 32'h000},
        '{1'b0, 32'h0000_0002, 32'h0000_0002, 32'h502, 32'h100, 32'h000},
        '{1'b1, 32'h0000_0040, 32'hFFFF_FFFF, 32'h502, 32'h100, 32'h040},
        '{1'b0, 32'h0000_0004, 32'h0000_0004, 32'h506, 32'h100, 32'h040},
        '{1'b1, 32'h0000_0030, 32'hFFFF_FFFF, 32'h502, 32'h030, 32'h030},
        '{1'b1, 32'h0000_0A00, 32'h0000_FF00, 32'h502, 32'h030, 32'hA30},
        '{1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFE0, 32'h502, 32'h030, 32'hA30},
        '{1'b0, 32'h0000_0004, 32'h0000_0004, 32'h506, 32'h030, 32'hA30},
        '{1'b0, 32'h0000_0000, 32'h0000_0002, 32'h504, 32'h030, 32'h000},
        '{1'b1, 32'h0000_0077, 32'hFFFF_FFFF, 32'h500, 32'h077, 32'h000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (match_o) begin
            nmatch++;
            last_match = cnt_val_i;
        end
    endtask

    task automatic wr_cfg(input logic [31:0] d, input logic [31:0] m);
        cfg_wr_i = 1'b1; wr_data_i = d; wr_mask_i = m;
        tick();
        cfg_wr_i = 1'b0;
    endtask

    task automatic wr_cmp(input logic [31:0] d, input logic [31:0] m);
        cmp_wr_i = 1'b1; wr_data_i = d; wr_mask_i = m;
        tick();
        cmp_wr_i = 1'b0;
    endtask

    task automatic sweep(input logic [31:0] start, input int n);
        nmatch = 0;
        cnt_en_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            cnt_val_i = start + 32'(i);
            tick();
        end
    endtask

    task automatic hold(input logic [31:0] v, input logic en, input int n);
        nmatch = 0;
        cnt_en_i = en;
        cnt_val_i = v;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements)");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 cfg", cfg_rd_o, 64'h00F0_0000_0000_0500);
        check("R1 cmp", 64'(cmp_rd_o), 64'hFFFF_FFFF);
        check("R1 period", 64'(period_rd_o), 64'h0);
        check("R1 match", 64'(match_o), 64'h0);

        // table: R2 R5 R6 R7 R8 steering with the counter stopped
        for (int k = 0; k < 10; k++) begin
            if (VEC[k].is_cmp) wr_cmp(VEC[k].data, VEC[k].mask);
            else               wr_cfg(VEC[k].data, VEC[k].mask);
            check($sformatf("row%0d R2 R6 cfg", k), cfg_rd_o, {32'h00F0_0000, VEC[k].exp_cfg});
            check($sformatf("row%0d R5 R7 cmp", k), 64'(cmp_rd_o), 64'(VEC[k].exp_cmp));
            check($sformatf("row%0d R5 R8 period", k), 64'(period_rd_o), 64'(VEC[k].exp_per));
        end

        // R3 inactive channel never matches
        sweep(32'h70, 16);
        check("R3 inactive matches", 64'(nmatch), 64'd0);

        // R4 one-shot single match
        hold(32'h0, 1'b0, 1);
        wr_cfg(32'h1, 32'h1F);
        sweep(32'h70, 16);
        check("R4 one-shot matches", 64'(nmatch), 64'd1);
        check("R4 match value", 64'(last_match), 64'h77);
        check("R9 one-shot cmp held", 64'(cmp_rd_o), 64'h77);

        // R4 disabled counter at comparator
        hold(32'h77, 1'b0, 5);
        check("R4 disabled matches", 64'(nmatch), 64'd0);

        // R9 one-shot rematch only after wrap
        sweep(32'hFFFF_FFFC, 128);
        check("R9 wrap matches", 64'(nmatch), 64'd1);

        // R3 periodic-only active, R9 periodic advance
        hold(32'h0, 1'b0, 1);
        wr_cfg(32'h6, 32'h1F);
        wr_cmp(32'h10, 32'hFFFF_FFFF);
        sweep(32'h0, 54);
        check("R3 R9 periodic matches", 64'(nmatch), 64'd3);
        check("R9 periodic cmp", 64'(cmp_rd_o), 64'h40);

        // R10 catch-up with remainder: 0x40 + 3*0x10
        hold(32'h65, 1'b0, 1);
        hold(32'h65, 1'b1, 8);
        check("R10 remainder cmp", 64'(cmp_rd_o), 64'h70);
        check("R10 no match", 64'(nmatch), 64'd0);

        // R10 exact multiple: 0x70 + 3*0x10
        hold(32'h90, 1'b0, 1);
        hold(32'h90, 1'b1, 8);
        check("R10 multiple cmp", 64'(cmp_rd_o), 64'hA0);
        check("R10 multiple no match", 64'(nmatch), 64'd0);

        // R11 unchanged control write while armed and overrun
        hold(32'hC5, 1'b1, 2);
        wr_cfg(32'h2, 32'h1F);
        hold(32'hC5, 1'b1, 6);
        check("R11 no-op write cmp", 64'(cmp_rd_o), 64'hA0);
        check("R11 no-op write cfg", cfg_rd_o, 64'h00F0_0000_0000_0502);

        // R10 restart of the same overrun does catch up: 0xA0 + 3*0x10
        hold(32'hC5, 1'b0, 1);
        hold(32'hC5, 1'b1, 8);
        check("R10 restart cmp", 64'(cmp_rd_o), 64'hD0);

        finish_run();
    end

endmodule